// File: doc/BRIEF.md
# Host Transmit FIFO Command Parser

This block sits on the read side of a host transmit FIFO. Each FIFO word is 36 bits: a 4-bit tag in bits [35:32] over a 32-bit body. The upstream transfer controller writes a start-of-packet command word, then any payload words, then an end-of-packet marker, and raises a one-cycle run strobe. The parser reads the command, checks it, and turns it into a transaction descriptor for the packet builder. It then forwards the payload words one at a time and returns exactly one completion, with an ok or error status, for every command it accepts.

Two recovery paths keep the transmit side from locking up. After a bus timeout the upstream side requests a purge. The parser then discards leftover entries until the FIFO runs dry or a start tag reaches the head, and it leaves that start word in place. A head word that is not a valid start command, a payload stream broken by a foreign tag, or a FIFO that stays empty too long all end the command with an error completion and a protocol-error pulse. A parser that stalls in the PID fetch waiting for data, or that misreads a stray word as a frame-number load, can hang the transmit side; these paths rule both out.

Top module: `txfifo_cmd_parser`

## Requirements
- R1: After reset every registered output is 0, the parser is idle and `fifo_pop` is 0.
- R2: In the fetch state, a head word with tag 0x0 and PID 0x1, 0x9, 0xD or 0x4 is popped. One cycle later `desc_valid` pulses with these fields: endpoint = bits [26:23], address = [22:16], speed = [9:8], type = [7:6], toggle = [5:4], PID = [3:0]. Bits [31:27] and [15:10] are ignored.
- R3: PIDs 0x1 and 0xD have a payload phase. Each tag 0x1 word is popped and shown on `data_word` with a one-cycle `data_valid`, and a tag 0x2 word is popped and ends the command with an ok completion. PIDs 0x9 and 0x4 complete ok in the same cycle as their descriptor.
- R4: Each accepted run strobe yields exactly one `done` pulse, and the parser is idle whenever `done` is high.
- R5: A fetched head word whose tag is not 0x0, or whose PID is not one of the four valid values, is not popped. It ends the command with `done`, `done_err` and `proto_err`, and no descriptor is produced.
- R6: If the FIFO stays empty for WAIT_LIMIT consecutive cycles while the parser waits for a command, it ends the command with `done`, `done_err` and `proto_err`.
- R7: A purge pops every non-start entry. It stops without popping when the FIFO is empty or the head carries tag 0x0, and then returns to idle.
- R8: During the payload phase, a head word with any tag other than 0x1 or 0x2 is left unpopped and ends the command with an error completion. WAIT_LIMIT consecutive empty cycles in this phase end it the same way.
- R9: `run_pkt` and `purge_req` are ignored unless the parser is idle. If both arrive together in idle, the purge wins and no completion is produced.
- R10: `fifo_pop` is high only while `fifo_empty` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_entry | input | 36 | Head word of the first-word-fall-through FIFO |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_pop | output | 1 | One-cycle read strobe that removes the head word |
| run_pkt | input | 1 | Upstream strobe: a command is waiting |
| purge_req | input | 1 | Upstream strobe: discard leftover entries after a bus timeout |
| desc_valid | output | 1 | Descriptor fields updated this cycle |
| desc_ep | output | 4 | Endpoint number |
| desc_addr | output | 7 | Device address |
| desc_speed | output | 2 | Endpoint speed |
| desc_type | output | 2 | Endpoint type |
| desc_toggle | output | 2 | Data toggle |
| desc_pid | output | 4 | Token PID |
| data_valid | output | 1 | `data_word` holds a new payload word |
| data_word | output | 32 | Payload word for the packet builder |
| done | output | 1 | Completion pulse to upstream |
| done_err | output | 1 | The completion carries an error status |
| proto_err | output | 1 | Protocol error pulse |

## Verification
The bench drives these stimulus patterns:
- Clean commands of each PID class: payload-bearing commands with several data words, and token-only commands. These separate the payload path from the immediate completion.
- Malformed heads: a data-tagged word at the head, and a start word with an unknown PID. These confirm the error path and that the bad word stays in the FIFO.
- A run with an empty FIFO, once left to time out and once fed late. This shows the bounded wait counts only consecutive empty cycles.
- Purges over mixed residue, ending at a start word, at an empty FIFO and at an empty FIFO from the outset. These fix where purging stops.
- Broken payload streams: a start word or an unknown tag arrives mid-payload, or the payload runs dry.
- A purge and a run strobe in the same cycle, and a run strobe while busy.

In every case a behavioural model in the bench predicts each output, and the bench compares it with the design on every clock.

// File: rtl/txfifo_parser_pkg.sv
package txfifo_parser_pkg;

    localparam int ENTRY_W = 36;
    localparam int TAG_W   = 4;
    localparam int WORD_W  = 32;

    localparam logic [TAG_W-1:0] TAG_START = 4'h0;
    localparam logic [TAG_W-1:0] TAG_DATA  = 4'h1;
    localparam logic [TAG_W-1:0] TAG_EOP   = 4'h2;

    localparam logic [3:0] PID_OUT   = 4'h1;
    localparam logic [3:0] PID_IN    = 4'h9;
    localparam logic [3:0] PID_SETUP = 4'hD;
    localparam logic [3:0] PID_PING  = 4'h4;

    typedef struct packed {
        logic [3:0] ep;
        logic [6:0] addr;
        logic [1:0] speed;
        logic [1:0] ep_type;
        logic [1:0] toggle;
        logic [3:0] pid;
    } txn_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DATA,
        ST_PURGE
    } pstate_t;

    function automatic logic pid_known(input logic [3:0] pid);
        return (pid == PID_OUT) || (pid == PID_IN) ||
               (pid == PID_SETUP) || (pid == PID_PING);
    endfunction

    function automatic logic pid_carries_data(input logic [3:0] pid);
        return (pid == PID_OUT) || (pid == PID_SETUP);
    endfunction

endpackage

// File: rtl/txfifo_entry_decode.sv
module txfifo_entry_decode
    import txfifo_parser_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    output logic               is_start,
    output logic               is_data,
    output logic               is_eop,
    output logic               cmd_ok,
    output logic               needs_data,
    output txn_desc_t          desc
);

    logic [TAG_W-1:0] tag;
    logic             rsvd_unused;

    always_comb begin
        tag          = entry[ENTRY_W-1 -: TAG_W];
        is_start     = (tag == TAG_START);
        is_data      = (tag == TAG_DATA);
        is_eop       = (tag == TAG_EOP);
        desc.ep      = entry[26:23];
        desc.addr    = entry[22:16];
        desc.speed   = entry[9:8];
        desc.ep_type = entry[7:6];
        desc.toggle  = entry[5:4];
        desc.pid     = entry[3:0];
        cmd_ok       = is_start && pid_known(desc.pid);
        needs_data   = pid_carries_data(desc.pid);
        rsvd_unused  = ^{entry[31:27], entry[15:10]};
    end

endmodule

// File: rtl/txfifo_wait_timer.sv
module txfifo_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic starved,
    output logic expired
);

    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = arm && starved && (cnt_q == CNT_W'(LIMIT - 1));
        cnt_d   = cnt_q;
        if (!arm || !starved || expired) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6: the count is cleared as soon as the parser stops waiting
    a_r6_clear_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> cnt_q == '0);

endmodule

// File: rtl/txfifo_cmd_parser.sv
module txfifo_cmd_parser
    import txfifo_parser_pkg::*;
#(
    parameter int WAIT_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [35:0] fifo_entry,
    input  logic        fifo_empty,
    output logic        fifo_pop,
    input  logic        run_pkt,
    input  logic        purge_req,
    output logic        desc_valid,
    output logic [3:0]  desc_ep,
    output logic [6:0]  desc_addr,
    output logic [1:0]  desc_speed,
    output logic [1:0]  desc_type,
    output logic [1:0]  desc_toggle,
    output logic [3:0]  desc_pid,
    output logic        data_valid,
    output logic [31:0] data_word,
    output logic        done,
    output logic        done_err,
    output logic        proto_err
);

    typedef struct packed {
        pstate_t             state;
        txn_desc_t           desc;
        logic                desc_valid;
        logic [WORD_W-1:0]   data_word;
        logic                data_valid;
        logic                done;
        logic                done_err;
        logic                proto_err;
    } regs_t;

    regs_t r_d, r_q;
    logic  pop_d;

    logic      hd_start, hd_data, hd_eop, hd_cmd_ok, hd_needs_data;
    txn_desc_t hd_desc;
    logic      wait_expired;

    txfifo_entry_decode u_decode (
        .entry      (fifo_entry),
        .is_start   (hd_start),
        .is_data    (hd_data),
        .is_eop     (hd_eop),
        .cmd_ok     (hd_cmd_ok),
        .needs_data (hd_needs_data),
        .desc       (hd_desc)
    );

    txfifo_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     ((r_q.state == ST_FETCH) || (r_q.state == ST_DATA)),
        .starved (fifo_empty),
        .expired (wait_expired)
    );

    always_comb begin
        r_d            = r_q;
        r_d.desc_valid = 1'b0;
        r_d.data_valid = 1'b0;
        r_d.done       = 1'b0;
        r_d.done_err   = 1'b0;
        r_d.proto_err  = 1'b0;
        pop_d          = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (purge_req) begin
                    r_d.state = ST_PURGE;
                end else if (run_pkt) begin
                    r_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (wait_expired) begin
                    r_d.done      = 1'b1;
                    r_d.done_err  = 1'b1;
                    r_d.proto_err = 1'b1;
                    r_d.state     = ST_IDLE;
                end else if (!fifo_empty) begin
                    if (hd_cmd_ok) begin
                        pop_d          = 1'b1;
                        r_d.desc       = hd_desc;
                        r_d.desc_valid = 1'b1;
                        if (hd_needs_data) begin
                            r_d.state = ST_DATA;
                        end else begin
                            r_d.done  = 1'b1;
                            r_d.state = ST_IDLE;
                        end
                    end else begin
                        r_d.done      = 1'b1;
                        r_d.done_err  = 1'b1;
                        r_d.proto_err = 1'b1;
                        r_d.state     = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (wait_expired) begin
                    r_d.done      = 1'b1;
                    r_d.done_err  = 1'b1;
                    r_d.proto_err = 1'b1;
                    r_d.state     = ST_IDLE;
                end else if (!fifo_empty) begin
                    if (hd_data) begin
                        pop_d          = 1'b1;
                        r_d.data_word  = fifo_entry[WORD_W-1:0];
                        r_d.data_valid = 1'b1;
                    end else if (hd_eop) begin
                        pop_d     = 1'b1;
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.done      = 1'b1;
                        r_d.done_err  = 1'b1;
                        r_d.proto_err = 1'b1;
                        r_d.state     = ST_IDLE;
                    end
                end
            end
            ST_PURGE: begin
                if (fifo_empty || hd_start) begin
                    r_d.state = ST_IDLE;
                end else begin
                    pop_d = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fifo_pop    = pop_d;
    assign desc_valid  = r_q.desc_valid;
    assign desc_ep     = r_q.desc.ep;
    assign desc_addr   = r_q.desc.addr;
    assign desc_speed  = r_q.desc.speed;
    assign desc_type   = r_q.desc.ep_type;
    assign desc_toggle = r_q.desc.toggle;
    assign desc_pid    = r_q.desc.pid;
    assign data_valid  = r_q.data_valid;
    assign data_word   = r_q.data_word;
    assign done        = r_q.done;
    assign done_err    = r_q.done_err;
    assign proto_err   = r_q.proto_err;

    a_r10_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    a_r2_desc_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> $past(fifo_pop));

    a_r3_data_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(fifo_pop));

    a_r7_start_pop_is_command: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && fifo_entry[35:32] == TAG_START) |=> desc_valid);

    a_r5_err_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_err || proto_err) |-> done);

    a_r4_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_q.state == ST_IDLE));

    a_r9_purge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && purge_req) |=> (r_q.state == ST_PURGE && !done));

endmodule

// File: tb/tb_txfifo_cmd_parser.sv
module tb_txfifo_cmd_parser;

    localparam int LIMIT = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [35:0] fifo_entry;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        run_pkt, purge_req;
    logic        desc_valid, data_valid, done, done_err, proto_err;
    logic [3:0]  desc_ep, desc_pid;
    logic [6:0]  desc_addr;
    logic [1:0]  desc_speed, desc_type, desc_toggle;
    logic [31:0] data_word;

    always #2 clk = ~clk;

    txfifo_cmd_parser #(.WAIT_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_entry(fifo_entry), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .run_pkt(run_pkt), .purge_req(purge_req),
        .desc_valid(desc_valid), .desc_ep(desc_ep), .desc_addr(desc_addr),
        .desc_speed(desc_speed), .desc_type(desc_type), .desc_toggle(desc_toggle),
        .desc_pid(desc_pid), .data_valid(data_valid), .data_word(data_word),
        .done(done), .done_err(done_err), .proto_err(proto_err)
    );

    logic [35:0] q[$];
    int checks = 0, failures = 0;
    int n_done = 0, n_err = 0;

    // reference model state: 0 idle, 1 fetch, 2 payload, 3 purge
    int          m_st = 0, m_wait = 0;
    logic        m_pop;
    logic        e_dv, e_datv, e_done, e_err, e_pe;
    logic [35:0] e_cmd;
    logic [31:0] e_word;
    logic        dut_pop_s;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic refresh();
        fifo_empty = (q.size() == 0);
        fifo_entry = (q.size() == 0) ? 36'h0 : q[0];
    endtask

    function automatic logic [35:0] mk_cmd(input logic [3:0] pid, input logic [3:0] ep,
                                           input logic [6:0] addr, input logic [1:0] spd,
                                           input logic [1:0] typ, input logic [1:0] tog);
        return {4'h0, 2'b11, 3'b101, ep, addr, 6'b101101, spd, typ, tog, pid};
    endfunction

    function automatic bit good_pid(input logic [3:0] p);
        return p == 4'h1 || p == 4'h9 || p == 4'hD || p == 4'h4;
    endfunction

    task automatic model_fail();
        e_done = 1; e_err = 1; e_pe = 1; m_st = 0;
    endtask

    task automatic model_step();
        bit          emp;
        logic [35:0] h;
        m_pop = 0; e_dv = 0; e_datv = 0; e_done = 0; e_err = 0; e_pe = 0;
        emp = (q.size() == 0);
        h   = emp ? 36'h0 : q[0];
        case (m_st)
            0: begin
                if (purge_req) m_st = 3;
                else if (run_pkt) begin m_st = 1; m_wait = 0; end
            end
            1, 2: begin
                if (emp) begin
                    m_wait++;
                    if (m_wait >= LIMIT) model_fail();
                end else begin
                    m_wait = 0;
                    if (m_st == 1) begin
                        if (h[35:32] == 4'h0 && good_pid(h[3:0])) begin
                            m_pop = 1; e_dv = 1; e_cmd = h;
                            if (h[3:0] == 4'h1 || h[3:0] == 4'hD) m_st = 2;
                            else begin e_done = 1; m_st = 0; end
                        end else model_fail();
                    end else begin
                        if (h[35:32] == 4'h1) begin
                            m_pop = 1; e_datv = 1; e_word = h[31:0];
                        end else if (h[35:32] == 4'h2) begin
                            m_pop = 1; e_done = 1; m_st = 0;
                        end else model_fail();
                    end
                end
            end
            default: begin
                if (emp || h[35:32] == 4'h0) m_st = 0;
                else m_pop = 1;
            end
        endcase
    endtask

    always @(negedge clk) begin
        #1 dut_pop_s = fifo_pop;
    end

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m_st = 0; m_wait = 0; e_dv = 0; e_datv = 0; e_done = 0; e_err = 0; e_pe = 0;
            e_cmd = 36'h0; e_word = 32'h0;
        end else begin
            model_step();
            chk(dut_pop_s == m_pop, "R10", "fifo_pop", dut_pop_s, m_pop);
            if (m_pop) void'(q.pop_front());
            refresh();
            chk(desc_valid == e_dv, "R2", "desc_valid", desc_valid, e_dv);
            chk({desc_ep, desc_addr, desc_speed, desc_type, desc_toggle, desc_pid} ==
                {e_cmd[26:23], e_cmd[22:16], e_cmd[9:4], e_cmd[3:0]}, "R2", "descriptor",
                {desc_ep, desc_addr, desc_speed, desc_type, desc_toggle, desc_pid},
                {e_cmd[26:23], e_cmd[22:16], e_cmd[9:4], e_cmd[3:0]});
            chk(data_valid == e_datv, "R3", "data_valid", data_valid, e_datv);
            chk(data_word == e_word, "R3", "data_word", data_word, e_word);
            chk(done == e_done, "R4", "done", done, e_done);
            chk(done_err == e_err, "R5", "done_err", done_err, e_err);
            chk(proto_err == e_pe, "R5", "proto_err", proto_err, e_pe);
            if (done) n_done++;
            if (done_err) n_err++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [35:0] w);
        q.push_back(w);
        refresh();
    endtask

    task automatic pulse(input bit run, input bit prg);
        @(negedge clk);
        run_pkt = run; purge_req = prg;
        @(negedge clk);
        run_pkt = 0; purge_req = 0;
    endtask

    task automatic expect_counts(input string req, input int d0, input int e0,
                                 input int dd, input int de);
        chk(n_done - d0 == dd, req, "completions", n_done - d0, dd);
        chk(n_err - e0 == de, req, "error completions", n_err - e0, de);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d0, e0;
        rst_n = 0; run_pkt = 0; purge_req = 0;
        refresh();
        step(4);
        // R1: reset state
        chk(fifo_pop == 0, "R1", "fifo_pop in reset", fifo_pop, 0);
        chk({desc_valid, data_valid, done, done_err, proto_err} == 5'b0, "R1", "pulses",
            {desc_valid, data_valid, done, done_err, proto_err}, 0);
        chk(data_word == 0 && desc_pid == 0, "R1", "held fields", data_word, 0);
        rst_n = 1;
        step(2);

        // R3: OUT command with three data words
        d0 = n_done; e0 = n_err;
        push(mk_cmd(4'h1, 4'h5, 7'h2A, 2'b10, 2'b10, 2'b01));
        for (int i = 0; i < 3; i++) push({4'h1, 32'hA5A5_0000 + 32'(i)});
        push({4'h2, 32'h0});
        pulse(1, 0);
        step(10);
        expect_counts("R3", d0, e0, 1, 0);
        chk(q.size() == 0, "R3", "fifo drained", q.size(), 0);

        // R3: token-only IN and PING commands
        d0 = n_done; e0 = n_err;
        push(mk_cmd(4'h9, 4'hF, 7'h7F, 2'b01, 2'b11, 2'b10));
        pulse(1, 0);
        step(5);
        push(mk_cmd(4'h4, 4'h1, 7'h01, 2'b00, 2'b01, 2'b00));
        pulse(1, 0);
        step(5);
        expect_counts("R3", d0, e0, 2, 0);

        // R5: data-tagged head, then purge clears it (R7)
        d0 = n_done; e0 = n_err;
        push({4'h1, 32'hDEAD_BEEF});
        pulse(1, 0);
        step(4);
        expect_counts("R5", d0, e0, 1, 1);
        chk(q.size() == 1, "R5", "bad head kept", q.size(), 1);
        pulse(0, 1);
        step(4);
        chk(q.size() == 0, "R7", "purge to empty", q.size(), 0);

        // R5: start tag with unknown PID
        d0 = n_done; e0 = n_err;
        push(mk_cmd(4'h3, 4'h2, 7'h10, 2'b00, 2'b00, 2'b00));
        pulse(1, 0);
        step(4);
        expect_counts("R5", d0, e0, 1, 1);
        chk(q.size() == 1, "R5", "unknown PID kept", q.size(), 1);
        step(1);
        q.delete(); refresh();

        // R6: empty FIFO times out
        d0 = n_done; e0 = n_err;
        pulse(1, 0);
        step(LIMIT - 2);
        chk(n_done == d0, "R6", "no early completion", n_done - d0, 0);
        step(6);
        expect_counts("R6", d0, e0, 1, 1);

        // R6: late arrival before the limit completes normally
        d0 = n_done; e0 = n_err;
        pulse(1, 0);
        step(LIMIT - 3);
        push(mk_cmd(4'h9, 4'h3, 7'h33, 2'b10, 2'b11, 2'b01));
        step(5);
        expect_counts("R6", d0, e0, 1, 0);

        // R7: purge stops at a start word and leaves it
        push({4'h1, 32'h1}); push({4'h2, 32'h0}); push({4'h7, 32'h2}); push({4'h1, 32'h3});
        push(mk_cmd(4'h9, 4'h6, 7'h44, 2'b00, 2'b10, 2'b11));
        pulse(0, 1);
        step(8);
        chk(q.size() == 1, "R7", "stop at start", q.size(), 1);
        chk(q.size() == 1 && q[0][35:32] == 4'h0, "R7", "head tag", q.size() ? q[0][35:32] : 4'hF, 0);
        d0 = n_done; e0 = n_err;
        pulse(1, 0);
        step(4);
        expect_counts("R7", d0, e0, 1, 0);

        // R7: purge on empty FIFO returns to idle
        pulse(0, 1);
        step(3);
        d0 = n_done; e0 = n_err;
        push(mk_cmd(4'h4, 4'h0, 7'h00, 2'b00, 2'b00, 2'b00));
        pulse(1, 0);
        step(4);
        expect_counts("R7", d0, e0, 1, 0);

        // R8: start word intrudes into the payload
        d0 = n_done; e0 = n_err;
        push(mk_cmd(4'hD, 4'h0, 7'h05, 2'b10, 2'b00, 2'b00));
        push({4'h1, 32'h1234_5678});
        push(mk_cmd(4'h9, 4'h1, 7'h05, 2'b10, 2'b11, 2'b01));
        pulse(1, 0);
        step(6);
        expect_counts("R8", d0, e0, 1, 1);
        chk(q.size() == 1, "R8", "intruder kept", q.size(), 1);
        pulse(1, 0);
        step(4);
        expect_counts("R8", d0, e0, 2, 1);

        // R8: unknown tag in payload
        d0 = n_done; e0 = n_err;
        push(mk_cmd(4'h1, 4'h2, 7'h06, 2'b00, 2'b00, 2'b01));
        push({4'hC, 32'h0});
        pulse(1, 0);
        step(5);
        expect_counts("R8", d0, e0, 1, 1);
        q.delete(); refresh();

        // R8: payload runs dry; R9: run while busy is ignored
        d0 = n_done; e0 = n_err;
        push(mk_cmd(4'h1, 4'h2, 7'h07, 2'b00, 2'b00, 2'b01));
        pulse(1, 0);
        step(2);
        pulse(1, 0);
        step(LIMIT + 4);
        expect_counts("R8", d0, e0, 1, 1);

        // R9: purge and run together, purge wins
        d0 = n_done; e0 = n_err;
        push({4'h1, 32'h9}); push({4'h1, 32'hA});
        pulse(1, 1);
        step(6);
        expect_counts("R9", d0, e0, 0, 0);
        chk(q.size() == 0, "R9", "purge ran", q.size(), 0);

        step(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule